// File: doc/BRIEF.md
# External Data Memory Bus Controller

This block carries out the data-memory accesses that a move-external instruction of an 8-bit microcontroller issues. One request names a 16-bit or an 8-bit address, a direction and, for a write, one byte. A select input sends the access either to a 1 KB expanded RAM on the chip or to a bus outside the chip. The block answers with a one-cycle done pulse, and with the byte on a read.

The on-chip RAM finishes in one clock and leaves every bus pin alone. The outside bus uses a fixed sequence of one-clock states. First the low address byte is placed on the shared low port and the address strobe goes high. The strobe then falls so that an outside latch can capture the address. The data byte follows, with an active-low read or write strobe held low for two clocks. A recovery state comes last. The high port carries the address high byte during a 16-bit access. During an 8-bit access it keeps showing its port latch, so that software can page the RAM. Every external access sends a pulse that tells the low port latch to load FFH. The address strobe can be sent to either of two alternate pins.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: With use_ext_i = 0, an accepted request reads or writes the on-chip RAM. A 16-bit request (wide_i = 1) uses address bits 9:0, so addresses wrap modulo 1024. An 8-bit request uses addr_i[7:0] in page 0. done_o is high in the cycle after the accepting edge, and on a read rdata_o holds the stored byte in that same cycle.
- R2: An on-chip access leaves the pins idle. ale_a_o and ale_b_o stay low, rd_no and wr_no stay high, p0_ff_o stays low, p0_o equals p0_latch_i, p0_oe_o is 1 and p2_o equals p2_latch_i.
- R3: In the first cycle after an external request is accepted, the address strobe is high and p0_o carries addr_i[7:0] with p0_oe_o = 1. In the second cycle the strobe is low and the same byte is still driven.
- R4: In an external write, the third cycle drives wdata_i on p0_o while wr_no is still high. wr_no is low in cycles 4 and 5. In cycle 6 wr_no is high again and the data byte is still driven.
- R5: In an external read, rd_no is low in cycles 4 and 5 with p0_oe_o = 0. The byte on p0_i at the edge that ends cycle 5 is returned on rdata_o together with done_o.
- R6: p0_ff_o pulses for exactly one cycle (cycle 1) per external access, which tells the low port latch to load FFH. It is never raised for an on-chip access.
- R7: During cycles 1 to 6 of an external access, p2_o equals addr_i[15:8] when wide_i = 1 and equals p2_latch_i when wide_i = 0.
- R8: The address strobe appears on ale_a_o when ale_sel_i[0] = 1 and on ale_b_o when ale_sel_i[1] = 1. An unselected pin stays low.
- R9: done_o is high in cycle 7 after an external request is accepted. A request made while an external access is running is ignored: it changes neither memory nor done_o.
- R10: rd_no and wr_no are never low at the same time, and both are high out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, accepted when no external access is running |
| use_ext_i | input | 1 | 1 sends the access to the outside bus, 0 to the on-chip RAM |
| wide_i | input | 1 | 1 for 16-bit addressing, 0 for 8-bit addressing |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write byte |
| ale_sel_i | input | 2 | Address strobe pin routing, bit 0 for pin A and bit 1 for pin B |
| p0_latch_i | input | 8 | Current low port latch value |
| p2_latch_i | input | 8 | Current high port latch value |
| p0_i | input | 8 | Byte read from the low port pins |
| rdata_o | output | 8 | Read byte, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |
| p0_o | output | 8 | Low port output byte (address or data) |
| p0_oe_o | output | 1 | Low port output enable |
| p2_o | output | 8 | High port output byte |
| ale_a_o | output | 1 | Address strobe on alternate pin A |
| ale_b_o | output | 1 | Address strobe on alternate pin B |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| p0_ff_o | output | 1 | Pulse that loads FFH into the low port latch |

## Verification
On-chip accesses are tried with a 16-bit address above 03FFH followed by a read of its wrapped alias, and with an 8-bit write whose high byte is junk, read back through a 16-bit address. Together these separate correct modulo-1024 and page-0 decoding from full-width or wrong-byte indexing. External write/read pairs are run once in 16-bit mode with strobe pin A and once in 8-bit mode with pin B and a paging latch value. A bus model latches the address on the strobe and stores data on the write strobe, so a wrong high port, wrong timing or wrong routing leads to a pin mismatch or bad read data. An on-chip write issued in the middle of an external read, followed by a read of the same location, shows whether requests made while busy are dropped.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_ALE_LO,
    SQ_SETUP,
    SQ_STROBE,
    SQ_RECOV
  } seq_state_e;
endpackage

// File: rtl/xmem_xram.sv
module xmem_xram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_q       <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/xmem_ext_seq.sv
module xmem_ext_seq
  import xmem_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int STROBE_LEN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wide_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    p0_i,
  input  logic [DW-1:0]    p0_latch_i,
  input  logic [AW-DW-1:0] p2_latch_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    p0_o,
  output logic             p0_oe_o,
  output logic [AW-DW-1:0] p2_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no,
  output logic             p0_ff_o
);
  localparam int CNT_W = $clog2(STROBE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_LEN - 1);

  seq_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [DW-1:0]  rdata_q;
  logic           we_q;
  logic           wide_q;
  logic           done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == SQ_RECOV);
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          state_q <= SQ_ADDR;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          we_q    <= we_i;
          wide_q  <= wide_i;
        end
        SQ_ADDR:   state_q <= SQ_ALE_LO;
        SQ_ALE_LO: state_q <= SQ_SETUP;
        SQ_SETUP: begin
          state_q <= SQ_STROBE;
          cnt_q   <= '0;
        end
        SQ_STROBE: begin
          if (cnt_q == CNT_LAST) begin
            state_q <= SQ_RECOV;
            if (!we_q) rdata_q <= p0_i;  // sample in last strobe-low cycle
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_RECOV: state_q <= SQ_IDLE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  logic addr_phase;
  logic data_phase;
  assign addr_phase = (state_q == SQ_ADDR) || (state_q == SQ_ALE_LO);
  assign data_phase = (state_q == SQ_SETUP) || (state_q == SQ_STROBE) ||
                      (state_q == SQ_RECOV);

  always_comb begin
    p0_o    = p0_latch_i;
    p0_oe_o = 1'b1;
    if (addr_phase) begin
      p0_o = addr_q[DW-1:0];
    end else if (data_phase) begin
      p0_o    = we_q ? wdata_q : '1;
      p0_oe_o = we_q;
    end
  end

  assign busy_o  = (state_q != SQ_IDLE);
  assign p2_o    = (busy_o && wide_q) ? addr_q[AW-1:DW] : p2_latch_i;
  assign ale_o   = (state_q == SQ_ADDR);
  assign p0_ff_o = (state_q == SQ_ADDR);
  assign rd_no   = !((state_q == SQ_STROBE) && !we_q);
  assign wr_no   = !((state_q == SQ_STROBE) && we_q);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  // Assertions
  p_addr_at_ale_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> (p0_oe_o && $stable(p0_o)));
  p_wdata_setup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> (p0_oe_o && $past(p0_oe_o) && $stable(p0_o)));
  p_wdata_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> (p0_oe_o && $stable(p0_o)));
  p_rd_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !p0_oe_o);
  p_ff_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p0_ff_o |=> !p0_ff_o);
  p_p2_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && wide_q) |-> $stable(p2_o));
  p_no_dual_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_no || wr_no));
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int XRAM_AW    = 10,
  parameter int STROBE_LEN = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     use_ext_i,
  input  logic                     wide_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [1:0]               ale_sel_i,
  input  logic [DATA_W-1:0]        p0_latch_i,
  input  logic [ADDR_W-DATA_W-1:0] p2_latch_i,
  input  logic [DATA_W-1:0]        p0_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o,
  output logic [DATA_W-1:0]        p0_o,
  output logic                     p0_oe_o,
  output logic [ADDR_W-DATA_W-1:0] p2_o,
  output logic                     ale_a_o,
  output logic                     ale_b_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic                     p0_ff_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              ext_busy;
  logic              ext_done;
  logic [DATA_W-1:0] ext_rdata;
  logic [DATA_W-1:0] xram_rdata;
  logic              ale;
  logic              accept;
  logic              xram_en;
  logic              ext_start;
  logic [XRAM_AW-1:0] xram_addr;
  logic              int_done_q;

  assign accept    = req_i && !ext_busy;  // requests while busy are dropped
  assign xram_en   = accept && !use_ext_i;
  assign ext_start = accept && use_ext_i;
  assign xram_addr = wide_i ? addr_i[XRAM_AW-1:0] : XRAM_AW'(addr_i[DATA_W-1:0]);

  xmem_xram #(
    .AW (XRAM_AW),
    .DW (DATA_W)
  ) u_xram (
    .clk_i   (clk_i),
    .en_i    (xram_en),
    .we_i    (we_i),
    .addr_i  (xram_addr),
    .wdata_i (wdata_i),
    .rdata_o (xram_rdata)
  );

  xmem_ext_seq #(
    .AW         (ADDR_W),
    .DW         (DATA_W),
    .STROBE_LEN (STROBE_LEN)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (ext_start),
    .wide_i     (wide_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .p0_i       (p0_i),
    .p0_latch_i (p0_latch_i),
    .p2_latch_i (p2_latch_i),
    .busy_o     (ext_busy),
    .done_o     (ext_done),
    .rdata_o    (ext_rdata),
    .p0_o       (p0_o),
    .p0_oe_o    (p0_oe_o),
    .p2_o       (p2_o),
    .ale_o      (ale),
    .rd_no      (rd_no),
    .wr_no      (wr_no),
    .p0_ff_o    (p0_ff_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_done_q <= 1'b0;
    else         int_done_q <= xram_en;
  end

  assign ale_a_o = ale && ale_sel_i[0];
  assign ale_b_o = ale && ale_sel_i[1];
  assign done_o  = ext_done || int_done_q;
  assign rdata_o = ext_done ? ext_rdata : xram_rdata;

  // Assertions
  p_xram_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !use_ext_i && !ext_busy) |=> done_o);
  p_xram_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !use_ext_i && !ext_busy) |=>
      (rd_no && wr_no && !ale_a_o && !ale_b_o && !p0_ff_o && (p2_o == p2_latch_i)));
  p_ale_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ale_a_o && !ale_sel_i[0]) || (ale_b_o && !ale_sel_i[1])) == 1'b0);
  p_busy_no_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(p0_ff_o) |-> !done_o);

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: tb/xmem_bus_ctrl_tb.sv
`timescale 1ns/1ps
module xmem_bus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, use_ext = 1'b0, wide = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [1:0]  ale_sel = 2'b01;
  logic [7:0]  p0_latch = 8'h96;
  logic [7:0]  p2_latch = 8'h5A;
  logic [7:0]  p0_in;
  logic [7:0]  rdata, p0_out, p2_out;
  logic        done, p0_oe, ale_a, ale_b, rd_n, wr_n, p0_ff;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    bit        is_rd;
    logic [7:0] data;
    string     tag;
  } exp_t;
  exp_t sb_q[$];

  logic [7:0] ext_mem [4096];
  logic [7:0] ext_ref [4096];
  logic [7:0] lat_q = '0;

  always #2 clk = ~clk;  // 250 MHz

  xmem_bus_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .use_ext_i(use_ext), .wide_i(wide),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .ale_sel_i(ale_sel),
    .p0_latch_i(p0_latch), .p2_latch_i(p2_latch), .p0_i(p0_in),
    .rdata_o(rdata), .done_o(done), .p0_o(p0_out), .p0_oe_o(p0_oe), .p2_o(p2_out),
    .ale_a_o(ale_a), .ale_b_o(ale_b), .rd_no(rd_n), .wr_no(wr_n), .p0_ff_o(p0_ff)
  );

  // outside latch and memory
  assign p0_in = ext_mem[{p2_out[3:0], lat_q}];
  always @(negedge clk) begin
    if (ale_a || ale_b) lat_q <= p0_out;
    if (!wr_n) ext_mem[{p2_out[3:0], lat_q}] <= p0_out;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk("R9 unexpected done", 16'(done), 16'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.is_rd) chk(e.tag, 16'(rdata), 16'(e.data));
      end
    end
  end

  task automatic xram_acc(input bit w, input bit wd, input logic [15:0] a,
                          input logic [7:0] d, input logic [7:0] exp_rd, input string tag);
    exp_t e;
    e.is_rd = !w; e.data = exp_rd; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    req = 1; use_ext = 0; we = w; wide = wd; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    chk("R1 on-chip done next cycle", 16'(done), 16'h1);
    chk("R2 strobes idle", {14'h0, rd_n, wr_n}, 16'h3);
    chk("R2 ale/ff idle", {13'h0, ale_a, ale_b, p0_ff}, 16'h0);
    chk("R2 ports follow latches", {p2_out, p0_out}, {p2_latch, p0_latch});
  endtask

  task automatic ext_acc(input bit w, input bit wd, input logic [15:0] a,
                         input logic [7:0] d, input logic [1:0] sel, input bit poke);
    exp_t e;
    logic [7:0] p2e;
    logic [11:0] idx;
    p2e = wd ? a[15:8] : p2_latch;
    idx = {p2e[3:0], a[7:0]};
    e.is_rd = !w; e.data = ext_ref[idx]; e.tag = "R5 external read data";
    if (w) ext_ref[idx] = d;
    sb_q.push_back(e);
    @(negedge clk);
    req = 1; use_ext = 1; we = w; wide = wd; addr = a; wdata = d; ale_sel = sel;
    for (int n = 1; n <= 7; n++) begin
      @(negedge clk);
      if (n == 1) req = 0;
      if (poke && n == 3) begin
        req = 1; use_ext = 0; we = 1; wide = 1; addr = 16'h0005; wdata = 8'hEE;
      end
      if (poke && n == 4) req = 0;
      if (n <= 6) chk("R7 high port", 16'(p2_out), 16'(p2e));
      case (n)
        1: begin
          chk("R3 addr phase p0", {7'h0, p0_oe, p0_out}, {8'h1, a[7:0]});
          chk("R8 ale pins", {14'h0, ale_a, ale_b}, {14'h0, sel[0], sel[1]});
          chk("R6 ff pulse", 16'(p0_ff), 16'h1);
        end
        2: begin
          chk("R3 ale low addr held", {6'h0, ale_a, ale_b, p0_out}, {8'h0, a[7:0]});
          chk("R6 ff single", 16'(p0_ff), 16'h0);
        end
        3: begin
          chk("R10 strobes high before data", {14'h0, rd_n, wr_n}, 16'h3);
          if (w) chk("R4 data setup", {7'h0, p0_oe, p0_out}, {8'h1, d});
        end
        4, 5: begin
          if (w) begin
            chk("R4 wr low", {14'h0, rd_n, wr_n}, 16'h2);
            chk("R4 data held", 16'(p0_out), 16'(d));
          end else begin
            chk("R5 rd low", {14'h0, rd_n, wr_n}, 16'h1);
            chk("R5 port released", 16'(p0_oe), 16'h0);
          end
        end
        6: begin
          chk("R10 strobes released", {14'h0, rd_n, wr_n}, 16'h3);
          if (w) chk("R4 data hold after wr", {7'h0, p0_oe, p0_out}, {8'h1, d});
          chk("R9 no early done", 16'(done), 16'h0);
        end
        default: chk("R9 done in cycle 7", 16'(done), 16'h1);
      endcase
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      ext_mem[i] = 8'h00;
      ext_ref[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    chk("R10 reset strobes high", {14'h0, rd_n, wr_n}, 16'h3);
    chk("R2 reset idle outputs", {12'h0, done, ale_a, ale_b, p0_ff}, 16'h0);
    chk("R2 reset ports", {p2_out, p0_out}, {p2_latch, p0_latch});
    rst_n = 1;
    @(negedge clk);
    xram_acc(1, 1, 16'h0405, 8'hA5, 8'h00, "R1 write");
    xram_acc(0, 1, 16'h0005, 8'h00, 8'hA5, "R1 wrap modulo 1024 read");
    xram_acc(1, 0, 16'h3312, 8'h3C, 8'h00, "R1 narrow write");
    xram_acc(0, 1, 16'h0012, 8'h00, 8'h3C, "R1 narrow page-0 read");
    ext_acc(1, 1, 16'h0234, 8'h5E, 2'b01, 0);
    ext_acc(0, 1, 16'h0234, 8'h00, 2'b01, 0);
    ext_acc(1, 0, 16'h7781, 8'hC3, 2'b10, 0);
    ext_acc(0, 0, 16'h0081, 8'h00, 2'b10, 1);
    xram_acc(0, 1, 16'h0005, 8'h00, 8'hA5, "R9 busy request ignored");
    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", 16'(sb_q.size()), 16'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule